// File: doc/BRIEF.md
# Programmable IO Window Address Decoder

This block steers outgoing IO traffic. It takes a physical address and returns the identifier of the target that should receive it. Software programs a bank of address windows. Each window has an inclusive start and an inclusive end at 1 MB granularity, an enable bit and a target identifier. An address that falls in no enabled window goes to a global default target.

Configuration goes through a simple 32-bit register port with separate read and write strobes. Lookups arrive on their own port as a 48-bit address with a valid strobe. One cycle later the block returns the selected target and a flag that tells whether a window matched or the default was used. Window 0 is preset at reset to cover the first megabyte, so early boot traffic has a route before software reprograms anything. Writes to any other window leave window 0 untouched.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, window 0 is enabled with start field 0, end field 0 and target 0. Windows 1 to 15 are disabled with all fields zero, and the default target is 0. As a result, a read of offset 0x000 returns 0x00000001, and a read of 0x008, 0x00C or 0x100 returns 0.
- R2: Window w (0 to 15) has three registers at base 0x10*w:
  - Start register at +0x0. Bits [31:4] hold address bits [47:20] and bit 0 is the enable.
  - End register at +0x8. Bits [31:4] hold the inclusive last address bits [47:20].
  - Target register at +0xC. Bits [3:0] hold the target.
  The default target sits in bits [3:0] at offset 0x100. Bits outside these fields read as 0. Read data appears on reg_rdata one cycle after reg_rd_en and is 0 in every other cycle.
- R3: Reads of any offset not listed in R2 return 0, for example 0x004, 0x104 or 0x200. Writes to such offsets change no register.
- R4: Window w hits when it is enabled and start ≤ lk_addr[47:20] ≤ end, with both bounds inclusive. Address bits [19:0] take no part in the match.
- R5: When several windows hit, the result carries the target of the lowest-numbered hitting window.
- R6: When no window hits, res_target is the default target and res_hit is 0. When a window hits, res_hit is 1.
- R7: Writing the start register with bit 0 clear takes the window out of decoding. The end and target registers keep their values.
- R8: res_valid is 1 exactly in the cycle after a cycle with lk_valid high. Back-to-back lookups give back-to-back results in order.
- R9: Writes to offsets outside 0x000 to 0x00F leave the window 0 registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd_en |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 48 | Lookup physical address |
| res_valid | output | 1 | Lookup result valid |
| res_target | output | 4 | Selected target identifier |
| res_hit | output | 1 | 1 when a window matched, 0 when the default was used |

## Verification
The hardest case to reach from the ports is the priority between overlapping windows. The stimulus programs a low-numbered window and a higher-numbered one whose ranges overlap, then probes addresses in the shared region. It then disables the lower window through its enable bit alone, so that the same addresses fall through to the higher window. It also probes the exact first and last megabyte of each range, plus the megabyte just outside each bound, so that off-by-one comparisons show up. A bench model of the register bank predicts every result.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    typedef enum logic [1:0] {
        FLD_NONE,
        FLD_START,
        FLD_END,
        FLD_TGT
    } field_e;

    // Offset within one 16-byte window slot selects the register.
    function automatic field_e slot_field(input logic [3:0] off);
        case (off)
            4'h0:    return FLD_START;
            4'h8:    return FLD_END;
            4'hC:    return FLD_TGT;
            default: return FLD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/win_regbank.sv
module win_regbank
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 16,
    parameter int FIELD_W = 28,
    parameter int TGT_W   = 4,
    parameter int RA_W    = 12,
    parameter int DW      = 32,
    parameter logic [RA_W-1:0] GLOBAL_OFF = 12'h100
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [RA_W-1:0]                   addr,
    input  logic [DW-1:0]                     wdata,
    output logic [DW-1:0]                     rdata,
    output logic [NUM_WIN-1:0]                cfg_en,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]   cfg_lo,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]   cfg_hi,
    output logic [NUM_WIN-1:0][TGT_W-1:0]     cfg_tgt,
    output logic [TGT_W-1:0]                  dflt_tgt
);
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [RA_W-1:0] BANK_END = RA_W'(NUM_WIN * 16);

    typedef struct packed {
        logic [NUM_WIN-1:0]              en;
        logic [NUM_WIN-1:0][FIELD_W-1:0] lo;
        logic [NUM_WIN-1:0][FIELD_W-1:0] hi;
        logic [NUM_WIN-1:0][TGT_W-1:0]   tgt;
        logic [TGT_W-1:0]                dflt;
        logic [DW-1:0]                   rdata;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [IDX_W-1:0] widx;
    logic             in_bank;
    field_e           fld;

    always_comb begin
        widx    = addr[4 +: IDX_W];
        in_bank = (addr < BANK_END);
        fld     = slot_field(addr[3:0]);

        bank_d       = bank_q;
        bank_d.rdata = '0;

        if (wr_en) begin
            if (in_bank) begin
                case (fld)
                    FLD_START: begin
                        bank_d.en[widx] = wdata[0];
                        bank_d.lo[widx] = wdata[4 +: FIELD_W];
                    end
                    FLD_END: bank_d.hi[widx]  = wdata[4 +: FIELD_W];
                    FLD_TGT: bank_d.tgt[widx] = wdata[TGT_W-1:0];
                    default: ;
                endcase
            end else if (addr == GLOBAL_OFF) begin
                bank_d.dflt = wdata[TGT_W-1:0];
            end
        end

        if (rd_en) begin
            if (in_bank) begin
                case (fld)
                    FLD_START: bank_d.rdata = DW'({bank_q.lo[widx], 4'b0000})
                                            | DW'(bank_q.en[widx]);
                    FLD_END:   bank_d.rdata = DW'({bank_q.hi[widx], 4'b0000});
                    FLD_TGT:   bank_d.rdata = DW'(bank_q.tgt[widx]);
                    default:   bank_d.rdata = '0;
                endcase
            end else if (addr == GLOBAL_OFF) begin
                bank_d.rdata = DW'(bank_q.dflt);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q       <= '0;
            bank_q.en[0] <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata    = bank_q.rdata;
    assign cfg_en   = bank_q.en;
    assign cfg_lo   = bank_q.lo;
    assign cfg_hi   = bank_q.hi;
    assign cfg_tgt  = bank_q.tgt;
    assign dflt_tgt = bank_q.dflt;

endmodule

// File: rtl/win_match.sv
module win_match #(
    parameter int NUM_WIN = 16,
    parameter int FIELD_W = 28
) (
    input  logic [FIELD_W-1:0]              key,
    input  logic [NUM_WIN-1:0]              cfg_en,
    input  logic [NUM_WIN-1:0][FIELD_W-1:0] cfg_lo,
    input  logic [NUM_WIN-1:0][FIELD_W-1:0] cfg_hi,
    output logic [NUM_WIN-1:0]              hit
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign hit[w] = cfg_en[w] && (key >= cfg_lo[w]) && (key <= cfg_hi[w]);
    end
endmodule

// File: rtl/win_prio.sv
module win_prio #(
    parameter int NUM_WIN = 16,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hit,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
    parameter int NUM_WIN    = 16,
    parameter int ADDR_W     = 48,
    parameter int GRAN_SHIFT = 20,
    parameter int RA_W       = 12,
    parameter int DW         = 32,
    parameter logic [RA_W-1:0] GLOBAL_OFF = 12'h100,
    localparam int FIELD_W = ADDR_W - GRAN_SHIFT,
    localparam int TGT_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic [TGT_W-1:0]  res_target,
    output logic              res_hit
);
    logic [NUM_WIN-1:0]              cfg_en;
    logic [NUM_WIN-1:0][FIELD_W-1:0] cfg_lo;
    logic [NUM_WIN-1:0][FIELD_W-1:0] cfg_hi;
    logic [NUM_WIN-1:0][TGT_W-1:0]   cfg_tgt;
    logic [TGT_W-1:0]                dflt_tgt;
    logic [NUM_WIN-1:0]              hit_vec;
    logic                            hit_any;
    logic [TGT_W-1:0]                hit_idx;

    win_regbank #(
        .NUM_WIN(NUM_WIN), .FIELD_W(FIELD_W), .TGT_W(TGT_W),
        .RA_W(RA_W), .DW(DW), .GLOBAL_OFF(GLOBAL_OFF)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .cfg_en(cfg_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_tgt(cfg_tgt), .dflt_tgt(dflt_tgt)
    );

    win_match #(.NUM_WIN(NUM_WIN), .FIELD_W(FIELD_W)) u_match (
        .key(lk_addr[ADDR_W-1:GRAN_SHIFT]),
        .cfg_en(cfg_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .hit(hit_vec)
    );

    win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hit(hit_vec), .any(hit_any), .idx(hit_idx)
    );

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [TGT_W-1:0] target;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid  = 1'b1;
            res_d.hit    = hit_any;
            res_d.target = hit_any ? cfg_tgt[hit_idx] : dflt_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_hit    = res_q.hit;
    assign res_target = res_q.target;

endmodule

// File: rtl/addr_window_decoder_chk.sv
module addr_window_decoder_chk #(
    parameter int FIELD_W = 28,
    parameter int TGT_W   = 4,
    parameter int RA_W    = 12,
    parameter int DW      = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [RA_W-1:0]    reg_addr,
    input logic [DW-1:0]      reg_rdata,
    input logic               lk_valid,
    input logic               res_valid,
    input logic               res_hit,
    input logic [TGT_W-1:0]   res_target,
    input logic [TGT_W-1:0]   dflt_tgt,
    input logic               hit_any,
    input logic               w0_en,
    input logic [FIELD_W-1:0] w0_lo,
    input logic [FIELD_W-1:0] w0_hi,
    input logic [TGT_W-1:0]   w0_tgt
);
    // R8
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R8
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R4
    hit_flag_matches_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_hit == $past(hit_any)));

    // R6
    miss_uses_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !hit_any |=> (res_target == $past(dflt_tgt)));

    // R2
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rdata == '0));

    // R9
    win0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && (reg_addr[RA_W-1:4] != '0) |=>
            $stable(w0_en) && $stable(w0_lo) && $stable(w0_hi) && $stable(w0_tgt));

endmodule

bind addr_window_decoder addr_window_decoder_chk #(
    .FIELD_W(FIELD_W), .TGT_W(TGT_W), .RA_W(RA_W), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .res_valid(res_valid), .res_hit(res_hit),
    .res_target(res_target), .dflt_tgt(dflt_tgt), .hit_any(hit_any),
    .w0_en(cfg_en[0]), .w0_lo(cfg_lo[0]), .w0_hi(cfg_hi[0]), .w0_tgt(cfg_tgt[0])
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_valid;
    logic [3:0]  res_target;
    logic        res_hit;

    always #2 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_target(res_target), .res_hit(res_hit)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model of the register bank, built from the requirements.
    logic        m_en  [16];
    logic [27:0] m_lo  [16];
    logic [27:0] m_hi  [16];
    logic [3:0]  m_tgt [16];
    logic [3:0]  m_dflt;

    // Scoreboard queues: expected target, hit flag and requirement tag.
    logic [3:0] q_tgt [$];
    logic       q_hit [$];
    string      q_tag [$];

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < 16; w++) begin
            m_en[w] = 1'b0; m_lo[w] = '0; m_hi[w] = '0; m_tgt[w] = '0;
        end
        m_en[0] = 1'b1;
        m_dflt  = '0;
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a < 12'h100) begin
            case (a[3:0])
                4'h0: begin m_en[a[7:4]] = d[0]; m_lo[a[7:4]] = d[31:4]; end
                4'h8: m_hi[a[7:4]]  = d[31:4];
                4'hC: m_tgt[a[7:4]] = d[3:0];
                default: ;
            endcase
        end else if (a == 12'h100) begin
            m_dflt = d[3:0];
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        check(reg_rdata == exp, tag,
              $sformatf("read 0x%03h got 0x%08h exp 0x%08h", a, reg_rdata, exp));
    endtask

    task automatic push_expect(input logic [47:0] a, input string tag);
        logic [27:0] key;
        bit found;
        key = a[47:20];
        found = 0;
        for (int w = 0; w < 16; w++) begin
            if (!found && m_en[w] && key >= m_lo[w] && key <= m_hi[w]) begin
                found = 1;
                q_tgt.push_back(m_tgt[w]);
                q_hit.push_back(1'b1);
            end
        end
        if (!found) begin
            q_tgt.push_back(m_dflt);
            q_hit.push_back(1'b0);
        end
        q_tag.push_back(tag);
    endtask

    task automatic lookup(input logic [47:0] a, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        push_expect(a, tag);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: compare every result with the head of the queue.
    always @(posedge clk) begin
        #1;
        if (rst_n && res_valid) begin
            if (q_tgt.size() == 0) begin
                check(0, "R8", "result with no pending lookup, got valid 1 exp 0");
            end else begin
                automatic logic [3:0] et = q_tgt.pop_front();
                automatic logic       eh = q_hit.pop_front();
                automatic string      tg = q_tag.pop_front();
                check(res_target == et && res_hit == eh, tg,
                      $sformatf("target %0d hit %0b exp target %0d hit %0b",
                                res_target, res_hit, et, eh));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        check(res_valid == 1'b0 && reg_rdata == 32'h0, "R1",
              $sformatf("outputs after reset valid %0b rdata 0x%08h exp 0 0", res_valid, reg_rdata));
        reg_read(12'h000, 32'h1, "R1");
        reg_read(12'h008, 32'h0, "R1");
        reg_read(12'h00C, 32'h0, "R1");
        reg_read(12'h010, 32'h0, "R1");
        reg_read(12'h100, 32'h0, "R1");
        lookup(48'h0000_000F_FFFF, "R1");
        lookup(48'h0000_0010_0000, "R6");

        // R2 programming and readback with masked bits
        reg_write(12'h100, 32'h0000_0009);
        reg_write(12'h030, 32'h0000_1001);
        reg_write(12'h038, 32'h0000_1FFF);
        reg_write(12'h03C, 32'hFFFF_FFF5);
        reg_read(12'h030, 32'h0000_1001, "R2");
        reg_read(12'h038, 32'h0000_1FF0, "R2");
        reg_read(12'h03C, 32'h0000_0005, "R2");
        reg_read(12'h100, 32'h0000_0009, "R2");

        // R4 inclusive bounds, R6 default on miss
        lookup(48'h0000_1000_0000, "R4");
        lookup(48'h0000_1FFF_FFFF, "R4");
        lookup(48'h0000_2000_0000, "R6");
        lookup(48'h0000_0FFF_FFFF, "R6");

        // R5 overlap: window 7 overlaps window 3
        reg_write(12'h070, 32'h0000_1501);
        reg_write(12'h078, 32'h0000_3000);
        reg_write(12'h07C, 32'h0000_000C);
        lookup(48'h0000_1800_0000, "R5");
        lookup(48'h0000_2500_0000, "R4");

        // R7 disable window 3 by clearing its enable bit only
        reg_write(12'h030, 32'h0000_1000);
        reg_read(12'h030, 32'h0000_1000, "R7");
        reg_read(12'h038, 32'h0000_1FF0, "R7");
        reg_read(12'h03C, 32'h0000_0005, "R7");
        lookup(48'h0000_1800_0000, "R7");
        lookup(48'h0000_1000_0000, "R7");

        // R3 unmapped offsets
        reg_write(12'h034, 32'hFFFF_FFFF);
        reg_write(12'h104, 32'hFFFF_FFFF);
        reg_write(12'h200, 32'hFFFF_FFFF);
        reg_read(12'h034, 32'h0, "R3");
        reg_read(12'h104, 32'h0, "R3");
        reg_read(12'h200, 32'h0, "R3");
        reg_read(12'h030, 32'h0000_1000, "R3");
        reg_read(12'h100, 32'h0000_0009, "R3");

        // Top of the address space in the last window
        reg_write(12'h0F0, 32'hFFFF_FFF1);
        reg_write(12'h0F8, 32'hFFFF_FFF0);
        reg_write(12'h0FC, 32'h0000_000F);
        reg_read(12'h0F0, 32'hFFFF_FFF1, "R2");
        lookup(48'hFFFF_FFF0_0000, "R4");
        lookup(48'hFFFF_FFEF_FFFF, "R6");

        // R9 window 0 unaffected by other writes
        reg_read(12'h000, 32'h1, "R9");
        reg_read(12'h008, 32'h0, "R9");
        reg_read(12'h00C, 32'h0, "R9");
        lookup(48'h0000_0005_0000, "R9");

        // R8 back-to-back lookups
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            lk_valid = 1'b1;
            lk_addr  = {20'h0, 28'(k) << 25};
            push_expect(lk_addr, "R8");
            @(negedge clk);
        end
        lk_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(q_tgt.size() == 0, "R8",
              $sformatf("pending results %0d exp 0", q_tgt.size()));
        check(res_valid == 1'b0, "R8",
              $sformatf("idle res_valid %0b exp 0", res_valid));

        finish_run();
    end
endmodule